// File: doc/BRIEF.md
# Overload Protection Fault Sequencer

This block is the digital supervisor of an off-line switch-mode power controller. It receives four comparator flags that are already synchronous to the system clock: the feedback node is above its overload level, the soft-start ramp has finished, the supply rail is above its turn-on level, and the supply rail is below its undervoltage level. From these it drives the power-switch gate enable, the enable of the control logic, the reset of the soft-start ramp, and a latched error flag.

An overload or open-loop fault counts only once soft start is complete and the feedback flag is also high. The condition must then hold for a programmable number of clock cycles before the switch is turned off. A pulse shorter than that is treated as a transient and restarts the count. After the switch is off, the sequencer does not use a timer to recover. It waits for the supply to sag below the undervoltage level, which shuts the control logic down. It then waits for the supply to climb back above the turn-on level, and only then starts again with a fresh soft start. The error flag clears at that restart.

Top module: `olp_fault_seq`

## Requirements
- R1: While rst_ni is low and after its release, the outputs are: gate_en_o=0, ctrl_en_o=0, ss_rst_o=1, err_o=0.
- R2: From the off state, one clock edge that samples vcc_on_i=1 and vcc_uv_i=0 starts soft start. After that edge, ctrl_en_o=1, gate_en_o=1 and ss_rst_o=0.
- R3: While ss_done_i=0, fb_over_i has no effect, and gate_en_o stays 1 for as long as the supply stays healthy.
- R4: The fault condition is fb_over_i=1 and ss_done_i=1 while running. Let the first edge that samples it be edge k. If it is sampled at every edge from k to k+DELAY_CYC, gate_en_o falls and err_o rises right after edge k+DELAY_CYC. Up to that point gate_en_o stays 1.
- R5: A fault condition that drops before the delay expires leaves the switch on. It also restarts the count, so a later fault again needs the full DELAY_CYC.
- R6: While latched, the outputs are: gate_en_o=0, ctrl_en_o=1, ss_rst_o=1, err_o=1.
- R7: vcc_uv_i=1, sampled in any state with ctrl_en_o=1, moves the sequencer to off after that edge: ctrl_en_o=0, gate_en_o=0, ss_rst_o=1. err_o keeps its value.
- R8: err_o clears only at the restart out of off, which means the supply has already been below the undervoltage level. That restart releases ss_rst_o and sets gate_en_o.
- R9: While latched, vcc_on_i=1 with vcc_uv_i=0 has no effect, and all four outputs stay at their latched values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_over_i | input | 1 | Feedback above overload threshold |
| ss_done_i | input | 1 | Soft-start ramp complete |
| vcc_on_i | input | 1 | Supply above turn-on threshold |
| vcc_uv_i | input | 1 | Supply below undervoltage threshold |
| gate_en_o | output | 1 | Power-switch gate enable |
| ctrl_en_o | output | 1 | Control-logic enable |
| ss_rst_o | output | 1 | Holds the soft-start ramp in reset |
| err_o | output | 1 | Latched overload error |

## Verification
The bench places the exact latch edge by checking the gate one edge before and one edge after DELAY_CYC. A counter that is off by one would drop the switch early or late. The bench breaks the fault just short of expiry and checks that the next fault needs the full delay again. A design that kept the partial count would trip too soon. It drives overload while soft start is still running, and drives the turn-on flag while latched. Either slip would let the switch trip during start-up or restart without a supply sag. A long random run with supply flags and feedback bursts is compared against a bench reference of the sequence, which catches wrong priority between undervoltage and the other conditions.

// File: rtl/olp_seq_pkg.sv
package olp_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_LATCH = 3'd4
  } seq_state_e;
endpackage

// File: rtl/olp_delay_cnt.sv
module olp_delay_cnt #(
  parameter int unsigned DELAY_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(DELAY_CYC - 1));

  // clears whenever the qualifying condition is absent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
    else                         cnt_q <= '0;
  end

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DELAY_CYC));
  a_r5_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !expired_o) |=> (cnt_q != '0));
endmodule

// File: rtl/olp_err_latch.sv
module olp_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);
endmodule

// File: rtl/olp_seq_fsm.sv
module olp_seq_fsm
  import olp_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fault_i,
  input  logic       ss_done_i,
  input  logic       vcc_on_i,
  input  logic       vcc_uv_i,
  input  logic       expired_i,
  output seq_state_e state_o,
  output logic       cnt_run_o,
  output logic       set_err_o,
  output logic       clr_err_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (vcc_on_i && !vcc_uv_i) state_d = ST_SOFT;
      ST_SOFT:  if (vcc_uv_i) state_d = ST_OFF;
                else if (ss_done_i) state_d = ST_RUN;
      ST_RUN:   if (vcc_uv_i) state_d = ST_OFF;
                else if (fault_i) state_d = ST_WAIT;
      ST_WAIT:  if (vcc_uv_i) state_d = ST_OFF;
                else if (!fault_i) state_d = ST_RUN;
                else if (expired_i) state_d = ST_LATCH;
      ST_LATCH: if (vcc_uv_i) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign cnt_run_o = (state_q == ST_WAIT) && fault_i;
  assign set_err_o = (state_q == ST_WAIT) && (state_d == ST_LATCH);
  assign clr_err_o = (state_q == ST_OFF) && (state_d == ST_SOFT);

  a_r3_soft_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT && !ss_done_i && !vcc_uv_i) |=> (state_q == ST_SOFT));
  a_r9_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && !vcc_uv_i) |=> (state_q == ST_LATCH));
  a_r5_drop_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !fault_i && !vcc_uv_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/olp_fault_seq.sv
module olp_fault_seq
  import olp_seq_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_over_i,
  input  logic ss_done_i,
  input  logic vcc_on_i,
  input  logic vcc_uv_i,
  output logic gate_en_o,
  output logic ctrl_en_o,
  output logic ss_rst_o,
  output logic err_o
);
  seq_state_e state;
  logic fault, cnt_run, expired, set_err, clr_err;

  assign fault = fb_over_i && ss_done_i;

  olp_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault),
    .ss_done_i (ss_done_i),
    .vcc_on_i  (vcc_on_i),
    .vcc_uv_i  (vcc_uv_i),
    .expired_i (expired),
    .state_o   (state),
    .cnt_run_o (cnt_run),
    .set_err_o (set_err),
    .clr_err_o (clr_err)
  );

  olp_delay_cnt #(.DELAY_CYC(DELAY_CYC)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cnt_run),
    .expired_o (expired)
  );

  olp_err_latch u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_err),
    .clr_i  (clr_err),
    .err_o  (err_o)
  );

  assign gate_en_o = (state == ST_SOFT) || (state == ST_RUN) || (state == ST_WAIT);
  assign ctrl_en_o = (state != ST_OFF);
  assign ss_rst_o  = (state == ST_OFF) || (state == ST_LATCH);

  a_r6_err_blocks_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !gate_en_o);
  a_r4_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(fb_over_i && ss_done_i));
  a_r8_clear_after_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(!ctrl_en_o));
  a_r2_fresh_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |-> $past(ss_rst_o));
  a_r7_uv_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_uv_i && ctrl_en_o) |=> !ctrl_en_o);
endmodule

// File: tb/olp_fault_seq_tb.sv
module olp_fault_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb = 1'b0, ssd = 1'b0, von = 1'b0, uv = 1'b0;
  logic gate, ctrl, ssr, err;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  olp_fault_seq #(.DELAY_CYC(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fb_over_i(fb), .ss_done_i(ssd),
    .vcc_on_i(von), .vcc_uv_i(uv), .gate_en_o(gate), .ctrl_en_o(ctrl),
    .ss_rst_o(ssr), .err_o(err));

  // reference of the required sequence: 0 off,1 soft,2 run,3 wait,4 latched
  int m_st = 0, m_cnt = 0;
  logic m_err = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_err <= 1'b0;
    end else begin
      case (m_st)
        0: if (von && !uv) begin m_st <= 1; m_err <= 1'b0; end
        1: if (uv) m_st <= 0; else if (ssd) m_st <= 2;
        2: if (uv) m_st <= 0; else if (fb && ssd) begin m_st <= 3; m_cnt <= 0; end
        3: if (uv) m_st <= 0;
           else if (!(fb && ssd)) m_st <= 2;
           else if (m_cnt == D-1) begin m_st <= 4; m_err <= 1'b1; end
           else m_cnt <= m_cnt + 1;
        default: if (uv) m_st <= 0;
      endcase
    end
  end

  function automatic logic [3:0] exp_out(int st, logic e);
    logic g, c, s;
    g = (st >= 1 && st <= 3);
    c = (st != 0);
    s = (st == 0 || st == 4);
    return {g, c, s, e};
  endfunction

  task automatic chk(string tag, logic [3:0] exp);
    total++;
    if ({gate, ctrl, ssr, err} !== exp) begin
      bad++;
      $display("FAIL %s: got gate/ctrl/ss/err=%b expected %b at %0t",
               tag, {gate, ctrl, ssr, err}, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state, during and after reset
    cycn(2);
    chk("R1 in reset", 4'b0010);
    rst_n = 1'b1;
    cyc();
    chk("R1 after release", 4'b0010);

    // R2 start
    von = 1'b1;
    cyc();
    chk("R2 soft start entry", 4'b1100);
    von = 1'b0;

    // R3 overload masked during soft start
    fb = 1'b1;
    cycn(3 * D);
    chk("R3 masked overload", 4'b1100);
    fb = 1'b0; ssd = 1'b1;
    cyc();
    chk("R3 run entry", 4'b1100);

    // R5 short fault, then full fault needs whole delay again
    fb = 1'b1;
    cycn(D);
    chk("R5 before expiry", 4'b1100);
    fb = 1'b0;
    cyc();
    chk("R5 fault dropped", 4'b1100);
    fb = 1'b1;
    cycn(D);
    chk("R5 count restarted", 4'b1100);
    // R4 one more edge completes the delay
    cyc();
    chk("R4 latch edge", 4'b0111);
    fb = 1'b0; ssd = 1'b0;

    // R6 latched hold, R9 turn-on flag ignored
    cycn(4);
    chk("R6 latched outputs", 4'b0111);
    von = 1'b1;
    cycn(5);
    chk("R9 turn-on ignored", 4'b0111);
    von = 1'b0;

    // R7 undervoltage shuts control off, err kept
    uv = 1'b1;
    cyc();
    chk("R7 uv from latched", 4'b0011);
    uv = 1'b0;
    cycn(3);
    chk("R8 err held in off", 4'b0011);

    // R8 restart clears err with fresh soft start
    von = 1'b1;
    cyc();
    chk("R8 restart", 4'b1100);
    von = 1'b0; ssd = 1'b1;
    cyc();
    chk("R4 no fault without fb", 4'b1100);
    uv = 1'b1;
    cyc();
    chk("R7 uv from run", 4'b0010);
    uv = 1'b0;

    // random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) fb  = ~fb;
      if ($urandom_range(13) == 0) ssd = ~ssd;
      if ($urandom_range(7)  == 0) von = ~von;
      uv = ($urandom_range(29) == 0);
      cyc();
      chk("R4 R7 random", exp_out(m_st, m_err));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule